// File: doc/BRIEF.md
# Per-Channel Bias Trim Stage

This block is a streaming stage placed between the digitiser sample stream and the outgoing data link of a multi-amplifier detector readout. Each incoming 16-bit unsigned sample carries the number of the amplifier channel it came from. It also carries a flag that marks it as an image pixel or an overscan pixel, and a flag that marks the first sample of a new row for that channel. The block subtracts a software-loaded signed offset that belongs to that channel. The result is clamped to the unsigned 16-bit range, so every output pixel is a two-byte word.

As an option, the block also corrects the baseline row by row. It sums the first N overscan pixels of each row of a channel, after the offset has been removed, where N is a power of two from 1 to 64. At the next row start of that channel it takes the mean by a right shift, and it subtracts that mean from every image pixel of the new row. Overscan pixels can either be kept in the output stream or removed from it.

Software loads the offsets and the mode through a simple write port. A channel's new offset is held aside and takes effect only at that channel's next row start, so no row ever mixes two offsets. Both ends of the block use valid/ready handshakes, and the block adds two register stages of latency.

Top module: `biasTrim`

## Requirements
- R1: A write to address c (0..15) loads a signed two's-complement 16-bit offset for channel c. Once it is active, each sample of channel c leaves as raw minus offset.
- R2: Every subtraction result is clamped: below 0 it gives 0, and above 65535 it gives 65535. It never wraps.
- R3: An offset write takes effect starting with the next accepted sample of that channel that has inRowStart=1, that sample included. Samples of a row already in progress keep the previous offset.
- R4: Each channel keeps its own offset, accumulator and baseline. Traffic on one channel does not change the values of another channel.
- R5: When config bit 0 is 1, each image pixel has the baseline of its row subtracted as well. The baseline is the floor of the sum of the first N offset-corrected overscan pixels of the previous row of that channel, divided by N, where N = 2^k and k is config bits 4:2 (values above 6 act as 6). Overscan pixels after the first N are not summed. The baseline is 0 until the first row start after reset.
- R6: With config bit 1 = 0, overscan pixels produce no output. With bit 1 = 1 they are output with the offset subtracted but no baseline subtracted.
- R7: When the output is not stalled, a sample accepted at clock edge t is presented on the output in the cycle after edge t+1.
- R8: While outValid=1 and outReady=0, the output holds its data, channel and flag. inReady drops only when that stall blocks both stages. No sample is lost or reordered.
- R9: After reset, outValid=0, inReady=1, all offsets and baselines are 0, and the config is 0, so image samples pass unchanged.
- R10: When config bit 0 is 0, no baseline is subtracted, even if a baseline has been accumulated. The config is written at address 16 (wrAddr bit 4 set) and takes effect immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample valid |
| inReady | output | 1 | Block can accept a sample |
| inData | input | 16 | Raw unsigned sample |
| inChan | input | 4 | Amplifier channel tag |
| inOvsc | input | 1 | 1 = overscan pixel, 0 = image pixel |
| inRowStart | input | 1 | First sample of a row for this channel |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | 0..15 channel offset, 16 config |
| wrData | input | 16 | Write data |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Sink accepts the output pixel |
| outData | output | 16 | Corrected pixel |
| outChan | output | 4 | Channel tag of the output pixel |
| outOvsc | output | 1 | Output pixel is overscan |

## Verification
The properties assume that the source holds inValid and its tag fields steady until the handshake completes, and that outReady is a free choice of the sink in each cycle. The stimulus drives every input on the falling edge and keeps a pending sample in place until it is accepted. It changes the outReady pattern only just after a rising edge. The configuration word is rewritten only once every sample in flight has drained. Offset writes are freely mixed with traffic, because the row-boundary staging makes them safe at any time.

// File: rtl/biasTrimPkg.sv
package biasTrimPkg;

  // mode word, low five bits of the config register
  typedef struct packed {
    logic [2:0] log2Len;   // overscan run length exponent
    logic       keepOvsc;  // pass overscan pixels downstream
    logic       ovscEn;    // subtract row baseline from image pixels
  } trimCfg_t;

  // per-sample strobes from control to datapath
  typedef struct packed {
    logic load;     // sample accepted this cycle
    logic drop;     // sample produces no output
    logic useBase;  // subtract row baseline
  } trimStrobe_t;

endpackage

// File: rtl/biasTrimCtrl.sv
module biasTrimCtrl
  import biasTrimPkg::*;
#(
  parameter int CHANS  = 16,
  parameter int DW     = 16,
  parameter int MAXLOG = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [$clog2(CHANS)-1:0] inChan,
  input  logic                     inOvsc,
  input  logic                     inRowStart,
  input  logic                     wrEn,
  input  logic [$clog2(CHANS):0]   wrAddr,
  input  logic [DW-1:0]            wrData,
  input  logic                     canAccept,
  input  logic [DW-1:0]            trimNow,
  output trimStrobe_t              strobe,
  output logic [DW-1:0]            offSel,
  output logic [DW-1:0]            baseSel
);

  localparam int CW   = $clog2(CHANS);
  localparam int AW   = CW + 1;
  localparam int ACCW = DW + MAXLOG;
  localparam int CNTW = MAXLOG + 2;
  localparam logic [2:0] KMAX = 3'(MAXLOG);

  trimCfg_t        cfg;
  logic [DW-1:0]   pendOff [CHANS];
  logic [DW-1:0]   actOff  [CHANS];
  logic [DW-1:0]   baseRow [CHANS];
  logic [ACCW-1:0] accSum  [CHANS];
  logic [CNTW-1:0] accCnt  [CHANS];

  logic            take;
  logic [2:0]      kEff;
  logic [CNTW-1:0] lenNow;
  logic [DW-1:0]   meanNow;

  always_comb begin
    take    = inValid && canAccept;
    kEff    = (cfg.log2Len > KMAX) ? KMAX : cfg.log2Len;
    lenNow  = CNTW'(1) << kEff;
    meanNow = DW'(accSum[inChan] >> kEff);
    offSel  = inRowStart ? pendOff[inChan] : actOff[inChan];
    baseSel = inRowStart ? meanNow : baseRow[inChan];
    strobe.load    = take;
    strobe.drop    = inOvsc && !cfg.keepOvsc;
    strobe.useBase = cfg.ovscEn && !inOvsc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
      for (int c = 0; c < CHANS; c++) begin
        pendOff[c] <= '0;
        actOff[c]  <= '0;
        baseRow[c] <= '0;
        accSum[c]  <= '0;
        accCnt[c]  <= '0;
      end
    end else begin
      if (wrEn && wrAddr[AW-1]) cfg <= trimCfg_t'(wrData[4:0]);
      for (int c = 0; c < CHANS; c++) begin
        if (wrEn && !wrAddr[AW-1] && wrAddr[CW-1:0] == CW'(c))
          pendOff[c] <= wrData;
        if (take && inChan == CW'(c)) begin
          if (inRowStart) begin
            actOff[c]  <= pendOff[c];
            baseRow[c] <= meanNow;
            accSum[c]  <= inOvsc ? ACCW'(trimNow) : '0;
            accCnt[c]  <= inOvsc ? CNTW'(1) : '0;
          end else if (inOvsc && accCnt[c] < lenNow) begin
            accSum[c] <= accSum[c] + ACCW'(trimNow);
            accCnt[c] <= accCnt[c] + CNTW'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/biasTrimPath.sv
module biasTrimPath
  import biasTrimPkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  trimStrobe_t   strobe,
  input  logic [DW-1:0] inData,
  input  logic [CW-1:0] inChan,
  input  logic          inOvsc,
  input  logic [DW-1:0] offSel,
  input  logic [DW-1:0] baseSel,
  input  logic          outReady,
  output logic          canAccept,
  output logic [DW-1:0] trimNow,
  output logic          outValid,
  output logic [DW-1:0] outData,
  output logic [CW-1:0] outChan,
  output logic          outOvsc
);

  localparam int XW = DW + 2;
  localparam logic signed [XW-1:0] TOPV = {2'b00, {DW{1'b1}}};

  function automatic logic [DW-1:0] clampU(input logic signed [XW-1:0] v);
    if (v < 0)         return '0;
    else if (v > TOPV) return '1;
    else               return v[DW-1:0];
  endfunction

  logic          aValid, aDrop, aUseBase, aOvsc;
  logic [DW-1:0] aTrim, aBase;
  logic [CW-1:0] aChan;
  logic          advance;
  logic signed [XW-1:0] diffIn, diffA;

  always_comb begin
    advance   = !outValid || outReady;
    canAccept = !aValid || advance;
    diffIn    = $signed({2'b00, inData}) - $signed({{2{offSel[DW-1]}}, offSel});
    trimNow   = clampU(diffIn);
    diffA     = $signed({2'b00, aTrim}) - $signed({2'b00, aUseBase ? aBase : {DW{1'b0}}});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aValid <= 1'b0; aDrop <= 1'b0; aUseBase <= 1'b0; aOvsc <= 1'b0;
      aTrim <= '0; aBase <= '0; aChan <= '0;
      outValid <= 1'b0; outData <= '0; outChan <= '0; outOvsc <= 1'b0;
    end else begin
      if (canAccept) begin
        aValid <= strobe.load;
        if (strobe.load) begin
          aTrim    <= trimNow;
          aBase    <= baseSel;
          aUseBase <= strobe.useBase;
          aDrop    <= strobe.drop;
          aChan    <= inChan;
          aOvsc    <= inOvsc;
        end
      end
      if (advance) begin
        outValid <= aValid && !aDrop;
        if (aValid && !aDrop) begin
          outData <= clampU(diffA);
          outChan <= aChan;
          outOvsc <= aOvsc;
        end
      end
    end
  end

endmodule

// File: rtl/biasTrim.sv
module biasTrim
  import biasTrimPkg::*;
#(
  parameter int CHANS  = 16,
  parameter int DW     = 16,
  parameter int MAXLOG = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [DW-1:0]            inData,
  input  logic [$clog2(CHANS)-1:0] inChan,
  input  logic                     inOvsc,
  input  logic                     inRowStart,
  input  logic                     wrEn,
  input  logic [$clog2(CHANS):0]   wrAddr,
  input  logic [DW-1:0]            wrData,
  output logic                     outValid,
  input  logic                     outReady,
  output logic [DW-1:0]            outData,
  output logic [$clog2(CHANS)-1:0] outChan,
  output logic                     outOvsc
);

  localparam int CW = $clog2(CHANS);

  trimStrobe_t   strobe;
  logic [DW-1:0] offSel, baseSel, trimNow;
  logic          canAccept;

  biasTrimCtrl #(.CHANS(CHANS), .DW(DW), .MAXLOG(MAXLOG)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inChan(inChan),
    .inOvsc(inOvsc), .inRowStart(inRowStart), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .canAccept(canAccept),
    .trimNow(trimNow), .strobe(strobe), .offSel(offSel), .baseSel(baseSel)
  );

  biasTrimPath #(.DW(DW), .CW(CW)) path_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .inChan(inChan), .inOvsc(inOvsc), .offSel(offSel), .baseSel(baseSel),
    .outReady(outReady), .canAccept(canAccept), .trimNow(trimNow),
    .outValid(outValid), .outData(outData), .outChan(outChan),
    .outOvsc(outOvsc)
  );

  assign inReady = canAccept;

endmodule

// File: rtl/biasTrimChk.sv
module biasTrimChk #(
  parameter int CHANS = 16,
  parameter int DW    = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic                     inReady,
  input logic                     inOvsc,
  input logic                     outValid,
  input logic                     outReady,
  input logic [DW-1:0]            outData,
  input logic [$clog2(CHANS)-1:0] outChan,
  input logic                     outOvsc
);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outChan) && $stable(outOvsc));

  // R8
  ready_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> outValid && !outReady);

  // R7
  rise_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid && inReady, 2));

  // R7
  image_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !inOvsc) ##1 (!outValid || outReady) |=> outValid);

endmodule

bind biasTrim biasTrimChk #(.CHANS(CHANS), .DW(DW)) chk_i (.*);

// File: tb/biasTrim_tb_top.sv
`timescale 1ns/1ps
module biasTrim_tb_top;

  typedef struct { int data; int chan; string tag; } exp_t;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        inValid = 1'b0, inOvsc = 1'b0, inRowStart = 1'b0;
  logic        inReady;
  logic [15:0] inData = '0;
  logic [3:0]  inChan = '0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        outValid, outOvsc;
  logic        outReady = 1'b1;
  logic [15:0] outData;
  logic [3:0]  outChan;

  always #2 clk = ~clk;

  biasTrim dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inChan(inChan), .inOvsc(inOvsc), .inRowStart(inRowStart),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outChan(outChan), .outOvsc(outOvsc)
  );

  int  nTests = 0, nFail = 0, rdyMode = 0;
  bit  finished = 0;
  int  pend[16], act[16], accM[16], cntM[16], baseM[16];
  bit  cEn = 0, cKeep = 0;
  int  cK = 0;
  exp_t q[$];

  function automatic int clampI(int v);
    if (v < 0) return 0;
    if (v > 65535) return 65535;
    return v;
  endfunction

  function automatic int sgn(int w);
    return (w >= 32768) ? w - 65536 : w;
  endfunction

  task automatic check(bit ok, string tag, string what, int got, int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic push(int d, int ch, string tag);
    exp_t e;
    e.data = d; e.chan = ch; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic writeReg(int addr, int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'(addr); wrData = 16'(data);
    @(posedge clk);
    #1 wrEn = 1'b0;
    if (addr < 16) pend[addr] = data;
    else begin
      cEn = data[0]; cKeep = data[1]; cK = (data >> 2) & 7;
      if (cK > 6) cK = 6;
    end
  endtask

  task automatic sendPix(int ch, int d, bit ov, bit rs, string tag);
    int off, tr;
    @(negedge clk);
    inValid = 1'b1; inChan = 4'(ch); inData = 16'(d); inOvsc = ov; inRowStart = rs;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1 inValid = 1'b0;
    if (rs) begin
      act[ch] = pend[ch]; baseM[ch] = accM[ch] >> cK; accM[ch] = 0; cntM[ch] = 0;
    end
    off = sgn(act[ch]);
    tr  = clampI(d - off);
    if (ov && cntM[ch] < (1 << cK)) begin accM[ch] += tr; cntM[ch]++; end
    if (ov) begin
      if (cKeep) push(tr, ch, tag);
    end else push(clampI(tr - (cEn ? baseM[ch] : 0)), ch, tag);
  endtask

  task automatic drain();
    int guard = 0;
    while (q.size() != 0 && guard < 5000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
  endtask

  // sink readiness, changed just after each rising edge
  initial forever begin
    @(posedge clk);
    #1 outReady <= (rdyMode == 0) ? 1'b1 : ($urandom_range(3) != 0);
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rstN && outValid && outReady) begin
      exp_t e;
      if (q.size() == 0) check(0, "R8", "unexpected output", int'(outData), -1);
      else begin
        e = q.pop_front();
        check(outData == 16'(e.data), e.tag, "data", int'(outData), e.data);
        check(outChan == 4'(e.chan), e.tag, "chan", int'(outChan), e.chan);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL R8 watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 16; c++) begin
      pend[c] = 0; act[c] = 0; accM[c] = 0; cntM[c] = 0; baseM[c] = 0;
    end
    repeat (5) @(negedge clk);
    check(outValid == 1'b0, "R9", "outValid in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R9", "inReady after reset", int'(inReady), 1);
    check(outValid == 1'b0, "R9", "outValid after reset", int'(outValid), 0);

    // R9: reset state passes samples unchanged
    sendPix(7, 12345, 0, 1, "R9");
    sendPix(7, 65535, 0, 0, "R9");
    sendPix(7, 0, 0, 0, "R9");

    // R1 / R4: per-channel offsets, interleaved channels
    writeReg(0, 1000);
    writeReg(1, 50);
    sendPix(0, 5000, 0, 1, "R1");
    sendPix(1, 5000, 0, 1, "R4");
    sendPix(0, 1500, 0, 0, "R1");
    sendPix(1, 60, 0, 0, "R4");
    sendPix(0, 1001, 0, 0, "R4");

    // R2: clamp at both ends
    writeReg(2, 500);
    writeReg(3, 16'hFF00);
    sendPix(2, 100, 0, 1, "R2");
    sendPix(3, 65500, 0, 1, "R2");
    sendPix(3, 0, 0, 0, "R2");
    sendPix(2, 500, 0, 0, "R2");

    // R3: mid-row write waits for the next row start
    writeReg(4, 300);
    sendPix(4, 1000, 0, 1, "R3");
    writeReg(4, 400);
    sendPix(4, 1000, 0, 0, "R3");
    sendPix(4, 1000, 0, 1, "R3");
    drain();

    // R5 / R6: baseline from first four overscan pixels, overscan kept
    writeReg(16, 11);
    writeReg(5, 100);
    sendPix(5, 1000, 0, 1, "R5");
    sendPix(5, 1100, 0, 0, "R5");
    sendPix(5, 110, 1, 0, "R6");
    sendPix(5, 120, 1, 0, "R6");
    sendPix(5, 130, 1, 0, "R6");
    sendPix(5, 140, 1, 0, "R6");
    sendPix(5, 900, 1, 0, "R5");
    sendPix(5, 900, 1, 0, "R5");
    sendPix(5, 1000, 0, 1, "R5");
    sendPix(5, 110, 0, 0, "R5");
    sendPix(5, 200, 1, 0, "R6");
    sendPix(5, 200, 1, 0, "R6");
    drain();

    // R10 / R6: baseline disabled, overscan dropped
    writeReg(16, 8);
    sendPix(5, 1000, 0, 1, "R10");
    sendPix(5, 170, 1, 0, "R6");
    sendPix(5, 1234, 0, 0, "R10");
    drain();

    // R8: random backpressure, mixed channels and flags
    writeReg(16, 7);
    rdyMode = 1;
    for (int i = 0; i < 400; i++) begin
      int ch;
      ch = $urandom_range(3);
      if ($urandom_range(15) == 0) writeReg(ch, $urandom_range(3000) - 500);
      sendPix(ch, $urandom_range(65535), $urandom_range(3) == 0,
              $urandom_range(7) == 0, "R8");
    end
    drain();
    check(q.size() == 0, "R8", "pending outputs", q.size(), 0);

    // R7: latency with the sink always ready
    rdyMode = 0;
    repeat (3) @(negedge clk);
    sendPix(9, 4242, 0, 1, "R7");
    @(negedge clk);
    check(outValid == 1'b0, "R7", "valid one cycle after accept", int'(outValid), 0);
    @(negedge clk);
    check(outValid == 1'b1, "R7", "valid in second cycle", int'(outValid), 1);
    drain();
    check(q.size() == 0, "R7", "pending outputs", q.size(), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule